// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM with Dual-Cycle Deselect

This block is a synthesizable synchronous static RAM. Each word holds two 9-bit bytes. Address, write data, the three chip enables and the write controls are all captured on the rising clock edge. A write can store the whole word through a global write strobe, or single bytes through a byte-write qualifier combined with per-byte selects. A selected cycle that stores no byte is a read. Burst address generation and tag comparison sit outside the block.

The read path runs in one of two modes, chosen by a mode input. In flow-through mode, data is driven in the cycle right after the read edge. In pipelined mode, it passes through one more output register and appears one cycle later. The output-drive state moves through a two-stage pipeline, so a deselect takes effect with the same lag as a read. After a read, the bus therefore stays driven for one full cycle past the deselect edge, and it is released only after the next edge. An asynchronous output enable gates the bus at once. A sleep input puts the device in standby: the stored contents are kept, no access takes place, and the bus is released.

The bus is modelled as a data output plus a drive flag (`dout_en`), so the block can sit in front of a pad tri-state. The full 256K-word depth is set through `ADDR_W = 18`. The default is smaller so that simulation stays light.

Top module: `sram_dcd`

## Requirements
- R1: While reset is asserted and after it is released, with no read issued, `dout_en` is 0 and `dout` is all zeros.
- R2: A cycle is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 are all present at the edge. Any other combination writes nothing and counts as a deselect.
- R3: A selected edge with `gw_n`=0 writes all 18 bits of `din`, whatever the values of `bwe_n` and `bw_n`.
- R4: With `gw_n`=1 and `bwe_n`=0, byte k is written only when `bw_n[k]`=0. Byte 0 is bits 8:0 and byte 1 is bits 17:9. Unselected bytes keep their stored value.
- R5: A selected edge that writes no byte is a read. This includes `bwe_n`=0 with `bw_n`=2'b11, and such an edge leaves the memory unchanged.
- R6: With `flow_thru`=1, the word read at edge n is driven on `dout` with `dout_en`=1 in the cycle right after edge n.
- R7: With `flow_thru`=0, the word read at edge n is not yet driven after edge n. It is driven after edge n+1.
- R8: When a read at edge m-1 is followed by a non-read edge m, the bus stays driven through the cycle after m, with the last read word in flow-through mode. After edge m+1 `dout_en` is 0 if m+1 is also not a read.
- R9: `oe_n`=1 forces `dout_en` to 0 and `dout` to zero with no clock edge needed. Returning it to 0 restores the pending output.
- R10: While `sleep`=1, `dout_en` is 0 at once and selected commands are ignored, so no write happens. After sleep ends the stored data is intact and the bus stays released until a new read.
- R11: Reads on consecutive edges deliver one word per cycle in both modes, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pipeline state (memory not cleared) |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low, stores every byte |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | N_BYTES | Per-byte write selects, active low |
| addr | input | ADDR_W | Word address |
| din | input | N_BYTES*BYTE_W | Write data |
| flow_thru | input | 1 | 1 = flow-through output, 0 = pipelined output |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high |
| dout | output | N_BYTES*BYTE_W | Read data, zero when not driven |
| dout_en | output | 1 | Bus drive flag |

## Verification
The bench goes after the edge where the bus is released. A design that drops the deselect as soon as it is sampled releases the bus one cycle early, in both modes. A design that lengthens the flow-through read by a cycle shows stale or missing words in the back-to-back stream. Byte-write corner cases are covered: a byte-write qualifier with no byte selected must read and leave memory intact, and a global write must override clear byte selects, so a wrong decode shows up as corrupted or missing halves of a word. Each of the three chip enables is turned off in turn during a write attempt. Sleep is combined with a selected write, so a design that still writes in standby, or keeps driving the bus, returns changed data or a driven bus.

// File: rtl/sram_dcd_pkg.sv
`timescale 1ns/1ps
package sram_dcd_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } sram_cmd_e;
endpackage

// File: rtl/sram_dcd_decode.sv
`timescale 1ns/1ps
module sram_dcd_decode
   import sram_dcd_pkg::*;
#(
   parameter int N_BYTES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ce1_n,
   input  logic               ce2,
   input  logic               ce3_n,
   input  logic               gw_n,
   input  logic               bwe_n,
   input  logic [N_BYTES-1:0] bw_n,
   input  logic               sleep,
   output sram_cmd_e          cmd,
   output logic [N_BYTES-1:0] wr_be
);
   logic               chip_on;
   logic [N_BYTES-1:0] lane_sel;

   always_comb begin
      chip_on = !ce1_n && ce2 && !ce3_n && !sleep;
      if (!gw_n)       lane_sel = '1;
      else if (!bwe_n) lane_sel = ~bw_n;
      else             lane_sel = '0;
      wr_be = chip_on ? lane_sel : '0;
      if (!chip_on)      cmd = CMD_IDLE;
      else if (|lane_sel) cmd = CMD_WRITE;
      else               cmd = CMD_READ;
   end

   p_gw_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce1_n && ce2 && !ce3_n && !sleep && !gw_n) |-> (&wr_be && cmd == CMD_WRITE));
   p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ce1_n && ce2 && !ce3_n) |-> (wr_be == '0 && cmd == CMD_IDLE));
   p_sleep_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (wr_be == '0 && cmd != CMD_READ));
endmodule

// File: rtl/sram_dcd_array.sv
`timescale 1ns/1ps
module sram_dcd_array #(
   parameter int ADDR_W  = 10,
   parameter int BYTE_W  = 9,
   parameter int N_BYTES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [N_BYTES*BYTE_W-1:0] din,
   input  logic [N_BYTES-1:0]        wr_be,
   input  logic                      rd_en,
   output logic [N_BYTES*BYTE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];
      logic [BYTE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (wr_be[b]) cells[addr] <= din[b*BYTE_W +: BYTE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     lane_q <= '0;
         else if (rd_en) lane_q <= cells[addr];
      end

      assign rd_data[b*BYTE_W +: BYTE_W] = lane_q;
   end

   p_rw_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (wr_be == '0));
endmodule

// File: rtl/sram_dcd_outpath.sv
`timescale 1ns/1ps
module sram_dcd_outpath #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic              standby,
   input  logic              flow_thru,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] out_data,
   output logic              drive
);
   logic              stg1_q;
   logic              stg2_q;
   logic [DATA_W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg1_q <= 1'b0;
         stg2_q <= 1'b0;
         pipe_q <= '0;
      end else begin
         stg1_q <= rd_fire;
         stg2_q <= standby ? 1'b0 : stg1_q;
         if (!standby) pipe_q <= rd_data;
      end
   end

   always_comb begin
      drive    = flow_thru ? (stg1_q || stg2_q) : stg2_q;
      out_data = flow_thru ? rd_data : pipe_q;
   end

   p_dcd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rd_fire) && !rd_fire && !standby) |=> drive);
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_fire && !$past(rd_fire)) |=> !drive);
   p_ft_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_thru && rd_fire) |=> (drive || !flow_thru));
endmodule

// File: rtl/sram_dcd.sv
`timescale 1ns/1ps
module sram_dcd
   import sram_dcd_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int BYTE_W  = 9,
   parameter int N_BYTES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ce1_n,
   input  logic                      ce2,
   input  logic                      ce3_n,
   input  logic                      gw_n,
   input  logic                      bwe_n,
   input  logic [N_BYTES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [N_BYTES*BYTE_W-1:0] din,
   input  logic                      flow_thru,
   input  logic                      oe_n,
   input  logic                      sleep,
   output logic [N_BYTES*BYTE_W-1:0] dout,
   output logic                      dout_en
);
   localparam int DATA_W = N_BYTES * BYTE_W;

   if (ADDR_W < 1 || ADDR_W > 18 || BYTE_W < 1 || N_BYTES < 1) begin : g_bad_cfg
      $error("sram_dcd: unsupported ADDR_W/BYTE_W/N_BYTES");
   end

   sram_cmd_e          cmd;
   logic [N_BYTES-1:0] wr_be;
   logic [DATA_W-1:0]  rd_data;
   logic [DATA_W-1:0]  out_data;
   logic               drive;

   sram_dcd_decode #(.N_BYTES(N_BYTES)) u_dec (
      .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .sleep(sleep),
      .cmd(cmd), .wr_be(wr_be)
   );

   sram_dcd_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_mem (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr_be(wr_be),
      .rd_en(cmd == CMD_READ), .rd_data(rd_data)
   );

   sram_dcd_outpath #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .rd_fire(cmd == CMD_READ), .standby(sleep),
      .flow_thru(flow_thru), .rd_data(rd_data), .out_data(out_data), .drive(drive)
   );

   always_comb begin
      dout_en = drive && !oe_n && !sleep;
      dout    = dout_en ? out_data : '0;
   end

   p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || sleep) |-> (!dout_en && dout == '0));
endmodule

// File: tb/tb_sram_dcd.sv
`timescale 1ns/1ps
module tb_sram_dcd;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
   logic        gw_n = 1'b1, bwe_n = 1'b1;
   logic [1:0]  bw_n = 2'b11;
   logic [9:0]  addr = '0;
   logic [17:0] din = '0;
   logic        flow_thru = 1'b1, oe_n = 1'b0, sleep = 1'b0;
   logic [17:0] dout;
   logic        dout_en;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   sram_dcd dut (
      .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr), .din(din),
      .flow_thru(flow_thru), .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
   );

   localparam logic [17:0] VA = 18'h2B1C7;
   localparam logic [17:0] VB = 18'h150F0;
   localparam logic [17:0] VC = 18'h1E3A9;
   localparam logic [17:0] VE = 18'h0C35D;
   localparam logic [17:0] VJ = 18'h3FFFF;
   logic [17:0] cur5;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_cmd(input logic [2:0] ces, input logic g, input logic bq,
                          input logic [1:0] b, input logic [9:0] a, input logic [17:0] d);
      {ce1_n, ce2, ce3_n} = ces;
      gw_n = g; bwe_n = bq; bw_n = b; addr = a; din = d;
   endtask

   task automatic idle();
      set_cmd(3'b100, 1'b1, 1'b1, 2'b11, '0, '0);
      tick();
   endtask

   task automatic rd(input logic [9:0] a);
      set_cmd(3'b010, 1'b1, 1'b1, 2'b11, a, '0);
      tick();
   endtask

   task automatic wr_all(input logic [9:0] a, input logic [17:0] d);
      set_cmd(3'b010, 1'b0, 1'b0, 2'b11, a, d);
      tick();
   endtask

   task automatic t_reset();
      repeat (3) tick();
      chk("R1 dout_en in reset", dout_en, 0);
      chk("R1 dout in reset", dout, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 dout_en after reset", dout_en, 0);
   endtask

   task automatic t_global();
      wr_all(10'd5, VA);
      rd(10'd5);
      chk("R3 global write overrides clear byte selects", dout, VA);
      chk("R6 flow-through drives after read edge", dout_en, 1);
      idle(); idle();
      cur5 = VA;
   endtask

   task automatic t_bytes();
      set_cmd(3'b010, 1'b1, 1'b0, 2'b10, 10'd5, VB);
      tick();
      cur5 = {cur5[17:9], VB[8:0]};
      rd(10'd5);
      chk("R4 byte0 only", dout, cur5);
      set_cmd(3'b010, 1'b1, 1'b0, 2'b01, 10'd5, VC);
      tick();
      cur5 = {VC[17:9], cur5[8:0]};
      rd(10'd5);
      chk("R4 byte1 only", dout, cur5);
      idle(); idle();
   endtask

   task automatic t_no_byte();
      set_cmd(3'b010, 1'b1, 1'b0, 2'b11, 10'd5, VJ);
      tick();
      chk("R5 qualifier without bytes reads", dout, cur5);
      chk("R5 read drives", dout_en, 1);
      idle();
      rd(10'd5);
      chk("R5 memory unchanged", dout, cur5);
      idle(); idle();
   endtask

   task automatic t_enables();
      wr_all(10'd7, VC);
      for (int k = 0; k < 3; k++) begin
         logic [2:0] pat;
         pat = 3'b010;
         pat[2-k] = ~pat[2-k];
         set_cmd(pat, 1'b0, 1'b0, 2'b00, 10'd7, VJ);
         tick();
      end
      idle();
      chk("R2 deselected cycles do not drive", dout_en, 0);
      rd(10'd7);
      chk("R2 no write while any enable inactive", dout, VC);
      idle(); idle();
   endtask

   task automatic t_pipe();
      flow_thru = 1'b0;
      wr_all(10'd8, VE);
      rd(10'd5);
      chk("R7 pipelined not yet driven", dout_en, 0);
      rd(10'd7);
      chk("R7 pipelined data one edge later", dout, cur5);
      chk("R7 pipelined drive", dout_en, 1);
      rd(10'd8);
      chk("R11 pipelined stream word 2", dout, VC);
      idle();
      chk("R11 pipelined stream word 3", dout, VE);
      chk("R8 pipelined drive held after deselect edge", dout_en, 1);
      idle();
      chk("R8 pipelined release after second edge", dout_en, 0);
      idle();
      flow_thru = 1'b1;
   endtask

   task automatic t_flow_dcd();
      rd(10'd7);
      chk("R6 flow-through data", dout, VC);
      idle();
      chk("R8 flow-through held data", dout, VC);
      chk("R8 flow-through held drive", dout_en, 1);
      idle();
      chk("R8 flow-through release", dout_en, 0);
      rd(10'd5);
      rd(10'd8);
      chk("R11 flow-through stream second word", dout, VE);
      idle(); idle();
   endtask

   task automatic t_oe();
      rd(10'd8);
      oe_n = 1'b1;
      #1;
      chk("R9 oe_n releases without clock", dout_en, 0);
      chk("R9 dout zero when disabled", dout, 0);
      oe_n = 1'b0;
      #1;
      chk("R9 restored output", dout, VE);
      idle(); idle();
   endtask

   task automatic t_sleep();
      rd(10'd7);
      sleep = 1'b1;
      set_cmd(3'b010, 1'b0, 1'b0, 2'b00, 10'd7, VJ);
      #1;
      chk("R10 sleep releases bus at once", dout_en, 0);
      tick();
      chk("R10 released during sleep", dout_en, 0);
      sleep = 1'b0;
      idle();
      chk("R10 no drive after wake", dout_en, 0);
      rd(10'd7);
      chk("R10 data retained and write ignored", dout, VC);
      idle(); idle();
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_global();
      t_bytes();
      t_no_byte();
      t_enables();
      t_pipe();
      t_flow_dcd();
      t_oe();
      t_sleep();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule